// File: doc/BRIEF.md
# NAND Bank Strobe and Select Decoder

This block bridges a CPU-side byte bus onto a shared 8-bit NAND flash bus with up to four banks. The banks share the strobe lines (CLE, ALE, WE#, RE#) and the data lines. Each bank has its own active-low chip enable. A control byte holds two bits for each bank: an enable bit and an assert bit. A bank's chip enable goes low only when both of its bits are set. Software therefore turns a bank on once, and then selects or releases chips by touching only the assert bits.

The CPU address space has two halves, chosen by the top address bit. The register half holds the control byte and a status byte. The status byte carries the ready/busy line after a two-flop synchroniser. The other half is the NAND window, and the offset inside it sets the cycle type. A write at offset 0x10000 is an address cycle, with ALE high. A write at offset 0x08000 is a command cycle, with CLE high. A write at any other offset is a data cycle. A read anywhere in the window is a data read: it pulses RE# and returns the byte captured from the bus. Each NAND cycle runs a setup phase, a strobe pulse and a hold phase, each a fixed number of clocks set by a parameter. The CPU request stays pending until `ready_o` pulses for one cycle.

Top module: `nand_bank_bridge`

## Requirements
- R1: After reset, every chip enable is high, CLE, ALE and the data output enable are low, WE# and RE# are high, and `ready_o` is low. A control read returns 0x00.
- R2: In the control byte (register offset 0x50), bank n has its enable bit at position 2n and its assert bit at position 2n+1. `nand_ce_no[n]` is low exactly when both bits are set.
- R3: A control read returns the last byte written. Writing a value with the assert bits (mask 0xAA) cleared releases every chip enable, and the enable bits still read back.
- R4: Writing 0x00 to the control byte drives every chip enable high.
- R5: A window write at offset 0x08000 is a command cycle. CLE is high and ALE is low for the whole cycle, and CLE and the data byte are stable when WE# falls and when WE# rises.
- R6: A window write at offset 0x10000 is an address cycle, with ALE high and CLE low. CLE and ALE are never high together.
- R7: A window write at any other offset is a data cycle with CLE and ALE low. `nand_dq_o` carries the written byte, and `nand_dq_oe_o` is high while WE# is low.
- R8: WE# is low for exactly T_PULSE clocks. `ready_o` pulses T_SETUP+T_PULSE+T_HOLD+1 clocks after the request is taken.
- R9: A window read pulses RE# low for T_PULSE clocks with the output enable low. `rdata_o` returns the bus byte as sampled in the last clock of the pulse, and the latency is the same as for a write.
- R10: The status byte (register offset 0x54) reports the ready/busy input in bit 0, through two flops. A status read that starts in the cycle after the input changes still returns the old value.
- R11: A register access returns `ready_o` one clock after it is taken. `ready_o` is never high in two consecutive cycles.
- R12: WE# and RE# are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request, held until ready_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Top bit selects registers (1) or NAND window (0); low bits are the offset |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte, valid with ready_o |
| ready_o | output | 1 | One-cycle completion pulse |
| nand_ce_no | output | NUM_BANKS | Chip enables, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe_o | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rb_i | input | 1 | Ready/busy from the flash |

## Verification
The bench raises a request on a falling edge and then samples once per clock until `ready_o` is seen. A register access is due on the first sample. A NAND cycle is due on sample T_SETUP+T_PULSE+T_HOLD+1, and the bench checks that count exactly. While it waits, the bench counts the low samples of WE# and RE# and records the levels of CLE, ALE, the output enable and the data bus. Each pulse width is therefore checked in whole clocks. Chip enables update on the same edge that takes a control write, so they are checked on the sample that shows `ready_o`. The ready/busy latency is checked by starting a status read in the clock right after a change of the input, where the old value is still due.

// File: rtl/nbb_pkg.sv
package nbb_pkg;
  typedef enum logic [1:0] {
    CYC_DATA = 2'd0,
    CYC_CMD  = 2'd1,
    CYC_ADDR = 2'd2
  } cyc_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_PULSE = 3'd2,
    ST_HOLD  = 3'd3,
    ST_DONE  = 3'd4
  } cyc_state_e;
endpackage

// File: rtl/nbb_decode.sv
module nbb_decode
  import nbb_pkg::*;
#(
  parameter int unsigned WIN_AW   = 17,
  parameter int unsigned CMD_OFS  = 'h08000,
  parameter int unsigned ADR_OFS  = 'h10000,
  parameter int unsigned CTRL_OFS = 'h50,
  parameter int unsigned STAT_OFS = 'h54,
  localparam int unsigned ADDR_W  = WIN_AW + 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              is_reg_o,
  output logic              sel_ctrl_o,
  output logic              sel_stat_o,
  output cyc_kind_e         kind_o
);
  logic [WIN_AW-1:0] ofs;

  assign ofs        = addr_i[WIN_AW-1:0];
  assign is_reg_o   = addr_i[ADDR_W-1];
  assign sel_ctrl_o = (ofs == WIN_AW'(CTRL_OFS));
  assign sel_stat_o = (ofs == WIN_AW'(STAT_OFS));

  // address offset wins over command offset, so both strobes can never be chosen
  always_comb begin
    if (ofs == WIN_AW'(ADR_OFS))      kind_o = CYC_ADDR;
    else if (ofs == WIN_AW'(CMD_OFS)) kind_o = CYC_CMD;
    else                              kind_o = CYC_DATA;
  end
endmodule

// File: rtl/nbb_ctrl_regs.sv
module nbb_ctrl_regs #(
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned CTRL_W   = 2 * NUM_BANKS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 acc_i,
  input  logic                 we_i,
  input  logic                 sel_ctrl_i,
  input  logic                 sel_stat_i,
  input  logic [7:0]           wdata_i,
  input  logic                 rb_i,
  output logic                 ack_o,
  output logic [7:0]           rdata_o,
  output logic [NUM_BANKS-1:0] ce_no
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              ack_q;
  logic [7:0]        rdata_q;
  logic              rb_meta_q, rb_sync_q;
  logic              take;

  assign take = acc_i && !ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rb_meta_q <= 1'b0;
      rb_sync_q <= 1'b0;
    end else begin
      rb_meta_q <= rb_i;
      rb_sync_q <= rb_meta_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= take;
      if (take && we_i && sel_ctrl_i) ctrl_q <= wdata_i[CTRL_W-1:0];
      if (take && !we_i) begin
        if (sel_ctrl_i)      rdata_q <= 8'(ctrl_q);
        else if (sel_stat_i) rdata_q <= {7'd0, rb_sync_q};
        else                 rdata_q <= '0;
      end
    end
  end

  for (genvar n = 0; n < NUM_BANKS; n++) begin : g_ce
    assign ce_no[n] = ~(ctrl_q[2*n] & ctrl_q[2*n+1]);
  end

  assign ack_o   = ack_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/nbb_cycle_fsm.sv
module nbb_cycle_fsm
  import nbb_pkg::*;
#(
  parameter int unsigned T_SETUP = 2,
  parameter int unsigned T_PULSE = 3,
  parameter int unsigned T_HOLD  = 2,
  localparam int unsigned T_MAX  = (T_SETUP > T_PULSE) ?
                                   ((T_SETUP > T_HOLD) ? T_SETUP : T_HOLD) :
                                   ((T_PULSE > T_HOLD) ? T_PULSE : T_HOLD),
  localparam int unsigned CNT_W  = $clog2(T_MAX + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       write_i,
  input  cyc_kind_e  kind_i,
  input  logic [7:0] wdata_i,
  input  logic [7:0] dq_i,
  output logic       done_o,
  output logic [7:0] rdata_o,
  output logic       cle_o,
  output logic       ale_o,
  output logic       we_no,
  output logic       re_no,
  output logic [7:0] dq_o,
  output logic       dq_oe_o
);
  cyc_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_q;
  cyc_kind_e        kind_q;
  logic [7:0]       wdata_q, rdata_q;
  logic             active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      kind_q  <= CYC_DATA;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SETUP;
          cnt_q   <= CNT_W'(T_SETUP - 1);
          wr_q    <= write_i;
          kind_q  <= write_i ? kind_i : CYC_DATA;
          wdata_q <= wdata_i;
        end
        ST_SETUP: begin
          if (cnt_q == '0) begin
            state_q <= ST_PULSE;
            cnt_q   <= CNT_W'(T_PULSE - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_PULSE: begin
          if (cnt_q == '0) begin
            state_q <= ST_HOLD;
            cnt_q   <= CNT_W'(T_HOLD - 1);
            if (!wr_q) rdata_q <= dq_i;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_HOLD: begin
          if (cnt_q == '0) state_q <= ST_DONE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign active  = (state_q == ST_SETUP) || (state_q == ST_PULSE) || (state_q == ST_HOLD);
  assign cle_o   = active && (kind_q == CYC_CMD);
  assign ale_o   = active && (kind_q == CYC_ADDR);
  assign we_no   = !((state_q == ST_PULSE) && wr_q);
  assign re_no   = !((state_q == ST_PULSE) && !wr_q);
  assign dq_oe_o = active && wr_q;
  assign dq_o    = wdata_q;
  assign done_o  = (state_q == ST_DONE);
  assign rdata_o = rdata_q;
endmodule

// File: rtl/nand_bank_bridge.sv
module nand_bank_bridge
  import nbb_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned WIN_AW    = 17,
  parameter int unsigned T_SETUP   = 2,
  parameter int unsigned T_PULSE   = 3,
  parameter int unsigned T_HOLD    = 2,
  localparam int unsigned ADDR_W   = WIN_AW + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [7:0]           wdata_i,
  output logic [7:0]           rdata_o,
  output logic                 ready_o,
  output logic [NUM_BANKS-1:0] nand_ce_no,
  output logic                 nand_cle_o,
  output logic                 nand_ale_o,
  output logic                 nand_we_no,
  output logic                 nand_re_no,
  output logic [7:0]           nand_dq_o,
  output logic                 nand_dq_oe_o,
  input  logic [7:0]           nand_dq_i,
  input  logic                 nand_rb_i
);
  logic       is_reg, sel_ctrl, sel_stat;
  cyc_kind_e  kind;
  logic       reg_ack, cyc_done;
  logic [7:0] reg_rdata, cyc_rdata;

  nbb_decode #(.WIN_AW(WIN_AW)) i_decode (
    .addr_i     (addr_i),
    .is_reg_o   (is_reg),
    .sel_ctrl_o (sel_ctrl),
    .sel_stat_o (sel_stat),
    .kind_o     (kind)
  );

  nbb_ctrl_regs #(.NUM_BANKS(NUM_BANKS)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (req_i && is_reg),
    .we_i       (we_i),
    .sel_ctrl_i (sel_ctrl),
    .sel_stat_i (sel_stat),
    .wdata_i    (wdata_i),
    .rb_i       (nand_rb_i),
    .ack_o      (reg_ack),
    .rdata_o    (reg_rdata),
    .ce_no      (nand_ce_no)
  );

  nbb_cycle_fsm #(.T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD)) i_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (req_i && !is_reg),
    .write_i (we_i),
    .kind_i  (kind),
    .wdata_i (wdata_i),
    .dq_i    (nand_dq_i),
    .done_o  (cyc_done),
    .rdata_o (cyc_rdata),
    .cle_o   (nand_cle_o),
    .ale_o   (nand_ale_o),
    .we_no   (nand_we_no),
    .re_no   (nand_re_no),
    .dq_o    (nand_dq_o),
    .dq_oe_o (nand_dq_oe_o)
  );

  assign ready_o = reg_ack | cyc_done;
  assign rdata_o = reg_ack ? reg_rdata : cyc_rdata;
endmodule

// File: rtl/nbb_checker.sv
module nbb_checker #(
  parameter int unsigned T_PULSE = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ready_o,
  input logic nand_cle_o,
  input logic nand_ale_o,
  input logic nand_we_no,
  input logic nand_re_no,
  input logic [7:0] nand_dq_o,
  input logic nand_dq_oe_o
);
  logic [15:0] we_lo_cnt, re_lo_cnt;
  logic        we_q, re_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_lo_cnt <= '0;
      re_lo_cnt <= '0;
      we_q      <= 1'b1;
      re_q      <= 1'b1;
    end else begin
      we_q      <= nand_we_no;
      re_q      <= nand_re_no;
      we_lo_cnt <= nand_we_no ? '0 : we_lo_cnt + 1'b1;
      re_lo_cnt <= nand_re_no ? '0 : re_lo_cnt + 1'b1;
    end
  end

  assert_cle_ale_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));
  assert_strobe_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nand_we_no && !nand_re_no));
  assert_ready_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  assert_setup_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(nand_we_no) |-> ($stable(nand_cle_o) && $stable(nand_ale_o) && $stable(nand_dq_o)));
  assert_hold_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nand_we_no) |-> ($stable(nand_cle_o) && $stable(nand_ale_o) && $stable(nand_dq_o)));
  assert_we_width_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nand_we_no && !we_q) |-> (we_lo_cnt == 16'(T_PULSE)));
  assert_re_width_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nand_re_no && !re_q) |-> (re_lo_cnt == 16'(T_PULSE)));
  assert_read_no_drive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_re_no |-> !nand_dq_oe_o);
endmodule

bind nand_bank_bridge nbb_checker #(.T_PULSE(T_PULSE)) i_nbb_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ready_o      (ready_o),
  .nand_cle_o   (nand_cle_o),
  .nand_ale_o   (nand_ale_o),
  .nand_we_no   (nand_we_no),
  .nand_re_no   (nand_re_no),
  .nand_dq_o    (nand_dq_o),
  .nand_dq_oe_o (nand_dq_oe_o)
);

// File: tb/test_nand_bank_bridge.sv
module test_nand_bank_bridge;
  localparam int NB = 4;
  localparam int AW = 18;
  localparam int SU = 2;
  localparam int PW = 3;
  localparam int HD = 2;
  localparam int LAT = SU + PW + HD + 1;
  localparam logic [AW-1:0] A_CTRL = {1'b1, 17'h00050};
  localparam logic [AW-1:0] A_STAT = {1'b1, 17'h00054};
  localparam logic [AW-1:0] A_CMD  = {1'b0, 17'h08000};
  localparam logic [AW-1:0] A_ADR  = {1'b0, 17'h10000};
  localparam logic [AW-1:0] A_DAT  = {1'b0, 17'h00000};

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata, dq_o, dq_i = '0;
  logic ready, cle, ale, we_n, re_n, dq_oe, rb = 1;
  logic [NB-1:0] ce_n;
  int checks = 0, fails = 0;

  // observations made during the last transfer
  int lat, we_lo, re_lo;
  logic saw_cle, saw_ale, saw_oe_lo;
  logic [7:0] dq_at_we;

  always #2 clk = ~clk;

  nand_bank_bridge #(.NUM_BANKS(NB), .WIN_AW(17), .T_SETUP(SU), .T_PULSE(PW), .T_HOLD(HD))
  i_nand_bank_bridge (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ready_o(ready), .nand_ce_no(ce_n), .nand_cle_o(cle), .nand_ale_o(ale),
    .nand_we_no(we_n), .nand_re_no(re_n), .nand_dq_o(dq_o), .nand_dq_oe_o(dq_oe),
    .nand_dq_i(dq_i), .nand_rb_i(rb));

  task automatic check(input logic ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", r, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [AW-1:0] a, input logic [7:0] d,
                      output logic [7:0] rd);
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d;
    lat = 0; we_lo = 0; re_lo = 0; saw_cle = 0; saw_ale = 0; saw_oe_lo = 0; dq_at_we = '0;
    rd = '0;
    forever begin
      @(negedge clk);
      lat++;
      if (cle) saw_cle = 1;
      if (ale) saw_ale = 1;
      if (!we_n) begin we_lo++; dq_at_we = dq_o; if (!dq_oe) saw_oe_lo = 1; end
      if (!re_n) begin re_lo++; if (dq_oe) saw_oe_lo = 1; end
      if (ready) begin rd = rdata; break; end
      if (lat > 100) begin check(0, "watchdog", lat, LAT); break; end
    end
    req = 0;
  endtask

  function automatic logic [NB-1:0] exp_ce(input logic [7:0] v);
    for (int n = 0; n < NB; n++) exp_ce[n] = ~(v[2*n] & v[2*n+1]);
  endfunction

  task automatic t_reset;
    logic [7:0] rd;
    check(ce_n == '1, "R1 ce", ce_n, 4'hF);
    check(!cle && !ale && !dq_oe, "R1 cle/ale/oe", {cle, ale, dq_oe}, 0);
    check(we_n && re_n, "R1 strobes", {we_n, re_n}, 3);
    check(!ready, "R1 ready", ready, 0);
    xfer(0, A_CTRL, 0, rd);
    check(rd == 8'h00, "R1 ctrl reset", rd, 0);
  endtask

  task automatic t_ctrl;
    logic [7:0] rd;
    logic [7:0] vals [4] = '{8'h03, 8'h0C, 8'h36, 8'h5F};
    for (int i = 0; i < 4; i++) begin
      xfer(1, A_CTRL, vals[i], rd);
      check(lat == 1, "R11 reg latency", lat, 1);
      check(ce_n == exp_ce(vals[i]), "R2 ce map", ce_n, exp_ce(vals[i]));
      xfer(0, A_CTRL, 0, rd);
      check(rd == vals[i], "R3 readback", rd, vals[i]);
    end
    xfer(1, A_CTRL, 8'hFF, rd);
    check(ce_n == '0, "R2 all selected", ce_n, 0);
    xfer(1, A_CTRL, 8'hFF & ~8'hAA, rd);
    check(ce_n == '1, "R3 deselect", ce_n, 4'hF);
    xfer(0, A_CTRL, 0, rd);
    check(rd == 8'h55, "R3 enables kept", rd, 8'h55);
    xfer(1, A_CTRL, 8'h00, rd);
    check(ce_n == '1, "R4 zero write", ce_n, 4'hF);
    xfer(0, A_CTRL, 0, rd);
    check(rd == 8'h00, "R4 readback", rd, 0);
  endtask

  task automatic t_cmd;
    logic [7:0] rd;
    xfer(1, A_CMD, 8'h70, rd);
    check(saw_cle && !saw_ale, "R5 cle only", {saw_cle, saw_ale}, 2);
    check(dq_at_we == 8'h70, "R5 cmd byte", dq_at_we, 8'h70);
    check(we_lo == PW, "R8 we width", we_lo, PW);
    check(lat == LAT, "R8 latency", lat, LAT);
  endtask

  task automatic t_addr;
    logic [7:0] rd;
    xfer(1, A_ADR, 8'hA5, rd);
    check(saw_ale && !saw_cle, "R6 ale only", {saw_cle, saw_ale}, 1);
    check(dq_at_we == 8'hA5, "R6 addr byte", dq_at_we, 8'hA5);
    check(lat == LAT, "R8 latency addr", lat, LAT);
  endtask

  task automatic t_data;
    logic [7:0] rd;
    xfer(1, A_DAT, 8'h3C, rd);
    check(!saw_ale && !saw_cle, "R7 no latch", {saw_cle, saw_ale}, 0);
    check(dq_at_we == 8'h3C && !saw_oe_lo, "R7 data byte", dq_at_we, 8'h3C);
    xfer(1, {1'b0, 17'h08001}, 8'hC3, rd);
    check(!saw_ale && !saw_cle, "R7 other offset", {saw_cle, saw_ale}, 0);
    check(we_lo == PW && re_lo == 0, "R12 only we", we_lo, PW);
  endtask

  task automatic t_read;
    logic [7:0] rd;
    dq_i = 8'h9E;
    xfer(0, A_DAT, 0, rd);
    check(rd == 8'h9E, "R9 read byte", rd, 8'h9E);
    check(re_lo == PW && we_lo == 0, "R9 re width", re_lo, PW);
    check(!saw_oe_lo && !saw_cle && !saw_ale, "R9 bus released", saw_oe_lo, 0);
    check(lat == LAT, "R9 latency", lat, LAT);
    dq_i = 8'h41;
    xfer(0, A_CMD, 0, rd);
    check(rd == 8'h41 && !saw_cle, "R9 read at cmd offset", rd, 8'h41);
  endtask

  task automatic t_rb;
    logic [7:0] rd;
    rb = 0;
    repeat (3) @(negedge clk);
    xfer(0, A_STAT, 0, rd);
    check(rd == 8'h00, "R10 busy", rd, 0);
    rb = 1;
    xfer(0, A_STAT, 0, rd);
    check(rd == 8'h00, "R10 sync delay", rd, 0);
    repeat (3) @(negedge clk);
    xfer(0, A_STAT, 0, rd);
    check(rd == 8'h01, "R10 ready", rd, 1);
  endtask

  initial begin
    #100000;
    check(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_cmd();
    t_addr();
    t_data();
    t_read();
    t_rb();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule